// File: doc/BRIEF.md
# Fetch Target Queue with Probe Filter

This block sits between a branch predictor and the instruction fetch stage. The predictor pushes predicted fetch-block addresses into a circular queue, and the fetch stage pops them in the same order. Because the two sides only meet through the queue, the predictor can run ahead while fetch waits on a cache miss, and fetch can drain queued work while the predictor stalls.

Two cursors walk the queued entries from oldest to youngest. The probe cursor uses spare instruction-cache lookups: whenever the cache reports an idle port, it sends the address of the next unprobed entry and records the answer. A hit tags the entry as not worth prefetching, and a miss tags it as worth prefetching. The prefetch cursor decides for each entry, exactly once, whether to emit a prefetch request. The rule it applies depends on a mode input. In strict mode only entries tagged as misses are sent. In loose mode every entry is sent except those tagged as hits. A mispredict flush empties the queue and parks both cursors at the head.

Top module: `fetch_target_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `deq_empty`=1, `enq_full`=0, `pf_valid`=0 and `probe_req`=0.
- R2: `deq_addr` shows the oldest queued address whenever `deq_empty`=0. Popping with `deq_pop`=1 removes that address, so addresses leave in the order they entered.
- R3: The queue holds DEPTH (32) entries. `enq_full` is 1 exactly when 32 entries are held. A push while full is dropped and never appears at the dequeue side.
- R4: A push and a pop in the same cycle are both accepted when the queue is neither full (for the push) nor empty (for the pop).
- R5: `probe_req` is 1 only when `probe_idle`=1 and the probe cursor points at a held entry that is unprobed and not yet considered for prefetch. `probe_addr` then carries that entry's address. Entries are probed oldest first.
- R6: `probe_hit` is sampled in the same cycle as `probe_req`. A value of 1 tags the entry as a hit (no prefetch), and 0 tags it as a miss (prefetch wanted). Newly pushed entries are untagged.
- R7: With `pf_mode`=0 (strict), an entry is sent only if it is tagged as a miss. The prefetch cursor waits at an untagged entry until that entry is probed or popped, and skips hit-tagged entries without output.
- R8: With `pf_mode`=1 (loose), untagged and miss-tagged entries are sent, and hit-tagged entries are skipped without output.
- R9: Entries are considered for prefetch in queue order, at most one per cycle, and each at most once. `pf_addr` carries the entry's address while `pf_valid`=1. An entry that has been popped is never considered afterwards.
- R10: The probe cursor passes over an entry already considered for prefetch in one cycle without asserting `probe_req`, whatever `probe_idle` is.
- R11: `flush`=1 suppresses `pf_valid` and `probe_req` in that cycle and drops any push or pop. The queue is empty in the next cycle, and later probing and prefetching start from the entries pushed after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Mispredict flush, empties the queue |
| enq_valid | input | 1 | Predictor pushes `enq_addr` |
| enq_addr | input | AW | Predicted fetch-block address |
| enq_full | output | 1 | Queue holds DEPTH entries |
| deq_pop | input | 1 | Fetch takes the oldest entry |
| deq_addr | output | AW | Oldest queued address |
| deq_empty | output | 1 | Queue holds no entry |
| probe_idle | input | 1 | A cache port is free for a probe this cycle |
| probe_req | output | 1 | Probe lookup issued this cycle |
| probe_addr | output | AW | Address being probed |
| probe_hit | input | 1 | Lookup result for `probe_addr`, same cycle |
| pf_mode | input | 1 | 0 strict, 1 loose |
| pf_valid | output | 1 | Prefetch request this cycle |
| pf_addr | output | AW | Address to prefetch |

## Verification
The assertions take for granted that `rst` is held high from time zero through at least one clock edge. They also assume every input carries a known value at each edge and that `probe_hit` answers the lookup made in the same cycle. The bench drives all inputs on the falling edge from its own tasks, holds reset for three cycles, and draws `probe_hit`, `probe_idle` and the mode from a random source. The probe answer therefore varies freely, but it only matters when a lookup is actually issued. Flushes are injected as single-cycle pulses between bursts of pushes and pops, including while the queue is full and while both cursors sit mid-queue.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    typedef enum logic [1:0] {
        PRB_NONE = 2'd0,
        PRB_MISS = 2'd1,
        PRB_HIT  = 2'd2
    } probe_state_e;

    localparam logic MODE_STRICT = 1'b0;
    localparam logic MODE_LOOSE  = 1'b1;

    typedef struct packed {
        logic resolve;
        logic send;
    } pf_verdict_t;

    function automatic pf_verdict_t pf_judge(input logic mode, input probe_state_e st);
        pf_verdict_t v;
        if (mode == MODE_LOOSE) begin
            v.resolve = 1'b1;
            v.send    = (st != PRB_HIT);
        end else begin
            v.resolve = (st != PRB_NONE);
            v.send    = (st == PRB_MISS);
        end
        return v;
    endfunction

endpackage

// File: rtl/ftq_store.sv
module ftq_store
    import ftq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic          mk_en,
    input  logic [IW-1:0] mk_idx,
    input  logic          mk_hit,
    input  logic          is_en,
    input  logic [IW-1:0] is_idx,
    input  logic [IW-1:0] ra_idx,
    output logic [AW-1:0] ra_addr,
    input  logic [IW-1:0] rb_idx,
    output logic [AW-1:0] rb_addr,
    output probe_state_e  rb_state,
    input  logic [IW-1:0] rc_idx,
    output logic [AW-1:0] rc_addr,
    output probe_state_e  rc_state,
    output logic          rc_issued
);

    logic [AW-1:0] addr_q [DEPTH];
    probe_state_e  st_q   [DEPTH];
    logic          iss_q  [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_idx == IW'(i)) begin
                addr_q[i] <= wr_addr;
            end
            if (rst) begin
                st_q[i]  <= PRB_NONE;
                iss_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                st_q[i]  <= PRB_NONE;
                iss_q[i] <= 1'b0;
            end else begin
                if (mk_en && mk_idx == IW'(i)) begin
                    st_q[i] <= mk_hit ? PRB_HIT : PRB_MISS;
                end
                if (is_en && is_idx == IW'(i)) begin
                    iss_q[i] <= 1'b1;
                end
            end
        end
    end

    assign ra_addr   = addr_q[ra_idx];
    assign rb_addr   = addr_q[rb_idx];
    assign rb_state  = st_q[rb_idx];
    assign rc_addr   = addr_q[rc_idx];
    assign rc_state  = st_q[rc_idx];
    assign rc_issued = iss_q[rc_idx];

endmodule

// File: rtl/ftq_cursor.sv
module ftq_cursor #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          adv,
    input  logic          deq_fire,
    input  logic [PW-1:0] head,
    input  logic [PW-1:0] tail,
    output logic [PW-1:0] cur
);

    logic [PW-1:0] step;
    logic [PW-1:0] nxt;

    always_comb begin
        step = cur + PW'(adv);
        nxt  = step;
        if (deq_fire && step == head) begin
            nxt = head + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (flush) begin
            cur <= head;
        end else begin
            cur <= nxt;
        end
    end

    // R9
    cursor_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (PW'(cur - head) <= PW'(tail - head)));

endmodule

// File: rtl/fetch_target_queue.sv
module fetch_target_queue
    import ftq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          enq_valid,
    input  logic [AW-1:0] enq_addr,
    output logic          enq_full,
    input  logic          deq_pop,
    output logic [AW-1:0] deq_addr,
    output logic          deq_empty,
    input  logic          probe_idle,
    output logic          probe_req,
    output logic [AW-1:0] probe_addr,
    input  logic          probe_hit,
    input  logic          pf_mode,
    output logic          pf_valid,
    output logic [AW-1:0] pf_addr
);

    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0] head_q, tail_q, scan_q, probe_q;
    logic          enq_fire, deq_fire;
    logic          scan_live, scan_adv;
    logic          probe_live, probe_fresh, probe_adv;
    logic [AW-1:0] scan_addr;
    probe_state_e  scan_st, probe_st;
    logic          probe_iss;
    pf_verdict_t   verdict;

    assign deq_empty = (head_q == tail_q);
    assign enq_full  = (PW'(tail_q - head_q) == PW'(DEPTH));
    assign enq_fire  = enq_valid && !enq_full && !flush;
    assign deq_fire  = deq_pop && !deq_empty && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            tail_q <= head_q;
        end else begin
            if (enq_fire) tail_q <= tail_q + PW'(1);
            if (deq_fire) head_q <= head_q + PW'(1);
        end
    end

    ftq_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (enq_fire),
        .wr_idx    (tail_q[IW-1:0]),
        .wr_addr   (enq_addr),
        .mk_en     (probe_req),
        .mk_idx    (probe_q[IW-1:0]),
        .mk_hit    (probe_hit),
        .is_en     (scan_adv),
        .is_idx    (scan_q[IW-1:0]),
        .ra_idx    (head_q[IW-1:0]),
        .ra_addr   (deq_addr),
        .rb_idx    (scan_q[IW-1:0]),
        .rb_addr   (scan_addr),
        .rb_state  (scan_st),
        .rc_idx    (probe_q[IW-1:0]),
        .rc_addr   (probe_addr),
        .rc_state  (probe_st),
        .rc_issued (probe_iss)
    );

    // prefetch cursor: decides each entry once, in order
    assign verdict   = pf_judge(pf_mode, scan_st);
    assign scan_live = (scan_q != tail_q);
    assign scan_adv  = scan_live && verdict.resolve && !flush;
    assign pf_valid  = scan_adv && verdict.send;
    assign pf_addr   = scan_addr;

    // probe cursor: uses idle cache ports, skips entries already decided
    assign probe_live  = (probe_q != tail_q) && !flush;
    assign probe_fresh = !probe_iss && (probe_st == PRB_NONE);
    assign probe_req   = probe_live && probe_fresh && probe_idle;
    assign probe_adv   = probe_live && (!probe_fresh || probe_idle);

    ftq_cursor #(.PW(PW)) scan_cur_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .adv      (scan_adv),
        .deq_fire (deq_fire),
        .head     (head_q),
        .tail     (tail_q),
        .cur      (scan_q)
    );

    ftq_cursor #(.PW(PW)) probe_cur_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .adv      (probe_adv),
        .deq_fire (deq_fire),
        .head     (head_q),
        .tail     (tail_q),
        .cur      (probe_q)
    );

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (deq_empty && !enq_full && !pf_valid && !probe_req));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enq_full && !deq_pop && !flush) |=> enq_full);

    // R4
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!enq_fire && !deq_fire && !flush) |=> ($stable(deq_empty) && $stable(enq_full)));

    // R9
    scan_moves_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid |=> (scan_q != $past(scan_q)));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> deq_empty);

endmodule

// File: tb/fetch_target_queue_tb.sv
module fetch_target_queue_tb_top;

    localparam int DEPTH = 32;
    localparam int AW    = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          enq_valid = 1'b0;
    logic [AW-1:0] enq_addr = '0;
    logic          enq_full;
    logic          deq_pop = 1'b0;
    logic [AW-1:0] deq_addr;
    logic          deq_empty;
    logic          probe_idle = 1'b0;
    logic          probe_req;
    logic [AW-1:0] probe_addr;
    logic          probe_hit = 1'b0;
    logic          pf_mode = 1'b0;
    logic          pf_valid;
    logic [AW-1:0] pf_addr;

    always #2 clk = ~clk;

    fetch_target_queue #(.DEPTH(DEPTH), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_full(enq_full),
        .deq_pop(deq_pop), .deq_addr(deq_addr), .deq_empty(deq_empty),
        .probe_idle(probe_idle), .probe_req(probe_req), .probe_addr(probe_addr),
        .probe_hit(probe_hit), .pf_mode(pf_mode),
        .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // behavioural reference: queues plus cursor offsets from the oldest entry
    logic [AW-1:0] m_addr [$];
    int            m_st   [$];   // 0 untagged, 1 miss, 2 hit
    bit            m_iss  [$];
    int            m_scan = 0;
    int            m_probe = 0;

    int            n_chk = 0;
    int            n_bad = 0;
    int            cycles = 0;
    string         phase = "R1";
    logic [AW-1:0] next_a = 32'h0000_1000;

    task automatic chk(string rq, string sig, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%h expected=%h", rq, phase, sig, act, exp);
        end
    endtask

    task automatic cyc(bit f, bit ev, bit dp, bit idle, bit hit, bit md);
        int sz;
        int st;
        bit s_res, s_send, e_pfv, p_live, p_fresh, e_preq, p_adv, ok_enq, ok_deq;
        @(negedge clk);
        flush = f; enq_valid = ev; enq_addr = next_a; deq_pop = dp;
        probe_idle = idle; probe_hit = hit; pf_mode = md;
        next_a = next_a + 32'h40;
        #1;
        sz = m_addr.size();
        s_res = 0; s_send = 0;
        if (!f && m_scan < sz) begin
            st = m_st[m_scan];
            s_res  = md || (st != 0);
            s_send = md ? (st != 2) : (st == 1);
        end
        e_pfv   = s_res && s_send;
        p_live  = !f && (m_probe < sz);
        p_fresh = p_live && !m_iss[m_probe] && (m_st[m_probe] == 0);
        e_preq  = p_fresh && idle;
        p_adv   = p_live && (!p_fresh || idle);

        chk("R3", "enq_full", AW'(enq_full), AW'(sz == DEPTH));
        chk("R2", "deq_empty", AW'(deq_empty), AW'(sz == 0));
        if (sz != 0) chk("R2", "deq_addr", deq_addr, m_addr[0]);
        chk("R5", "probe_req", AW'(probe_req), AW'(e_preq));
        if (e_preq) chk("R5", "probe_addr", probe_addr, m_addr[m_probe]);
        chk(md ? "R8" : "R7", "pf_valid", AW'(pf_valid), AW'(e_pfv));
        if (e_pfv) chk("R9", "pf_addr", pf_addr, m_addr[m_scan]);

        if (f) begin
            m_addr.delete(); m_st.delete(); m_iss.delete();
            m_scan = 0; m_probe = 0;
        end else begin
            ok_enq = ev && (sz < DEPTH);
            ok_deq = dp && (sz > 0);
            if (e_preq) m_st[m_probe] = hit ? 2 : 1;
            if (s_res) begin
                m_iss[m_scan] = 1'b1;
                m_scan++;
            end
            if (p_adv) m_probe++;
            if (ok_enq) begin
                m_addr.push_back(enq_addr);
                m_st.push_back(0);
                m_iss.push_back(1'b0);
            end
            if (ok_deq) begin
                void'(m_addr.pop_front());
                void'(m_st.pop_front());
                void'(m_iss.pop_front());
                if (m_scan > 0) m_scan--;
                if (m_probe > 0) m_probe--;
            end
        end
    endtask

    task automatic rnd_run(int n, int flush_odds, bit fixed_mode, bit md);
        for (int i = 0; i < n; i++) begin
            cyc(($urandom % flush_odds) == 0, ($urandom % 3) != 0, ($urandom % 2) == 0,
                ($urandom % 2) == 0, ($urandom % 2) == 0,
                fixed_mode ? md : 1'($urandom % 2));
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog [%s] cycles actual=%0d expected<=150000", phase, cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "deq_empty", AW'(deq_empty), AW'(1));
        chk("R1", "enq_full", AW'(enq_full), AW'(0));
        chk("R1", "pf_valid", AW'(pf_valid), AW'(0));
        chk("R1", "probe_req", AW'(probe_req), AW'(0));
        rst = 1'b0;

        // R2: order of departure, loose mode with no probes
        phase = "R2";
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 1);

        // R3: fill past capacity in strict mode, then drain
        phase = "R3";
        for (int i = 0; i < 36; i++) cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 34; i++) cyc(0, 0, 1, 0, 0, 0);

        // R6 and R7: strict mode, probes tag entries, scan waits for tags
        phase = "R6";
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 24; i++) cyc(0, 0, 0, ($urandom % 3) != 0, i[0], 0);
        phase = "R7";
        for (int i = 0; i < 12; i++) cyc(0, 1, ($urandom % 4) == 0, ($urandom % 2) == 0, i[1], 0);
        for (int i = 0; i < 30; i++) cyc(0, 0, 1, 1, 0, 0);

        // R8: loose mode with mixed tags
        phase = "R8";
        for (int i = 0; i < 8; i++) cyc(0, 1, 0, 1, i[0], 0);
        for (int i = 0; i < 20; i++) cyc(0, ($urandom % 2) == 0, 0, ($urandom % 2) == 0, ($urandom % 2) == 0, 1);
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 0, 1);

        // R10: loose scan decides everything first, probe then skips
        phase = "R10";
        for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 1, 1);
        for (int i = 0; i < 14; i++) cyc(0, 0, 1, 1, 0, 1);

        // R11: flush mid-queue, with push and pop requested in that cycle
        phase = "R11";
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, i[0], 0, 0);
        cyc(1, 1, 1, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 1, i[0], 0);
        for (int i = 0; i < 34; i++) cyc(0, 1, 0, 0, 0, 1);
        cyc(1, 1, 0, 1, 0, 1);
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1, 0, 1);

        // R4: simultaneous push and pop under both modes
        phase = "R4";
        for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 200; i++) cyc(0, 1, 1, ($urandom % 2) == 0, ($urandom % 2) == 0, 1'(i / 100));
        rnd_run(300, 1000000, 1, 0);

        // R5 and R9: long mixed traffic with rare flushes
        phase = "R5";
        rnd_run(1500, 64, 0, 0);
        phase = "R9";
        rnd_run(800, 200, 1, 1);

        finish_run();
    end

endmodule